// File: doc/BRIEF.md
# Page-Mode DRAM Controller with Background Refresh

This block converts single-bit read and write requests from a synchronous valid/ready port into the strobe sequences of a memory whose address pins are shared between row and column. The upper part of each request address selects a row and the lower part selects a column. A row is opened by presenting its address and pulling the row strobe low. The column address is then presented with the column strobe low, and the write strobe is also low if the request is a write. Every phase length is a parameter counted in clock cycles.

After an access the row stays open. A later request to the same row skips the row phase and costs only a short page cycle. A request to a different row first returns the row strobe high for the rewrite time and then opens the new row.

A refresh scheduler raises a request once per refresh interval. The refresh interval is the retention window divided by the number of rows. When the current access ends, the refresh takes priority over any waiting request. It closes an open row and then runs a row-strobe-only cycle on the row held in a wrapping counter, so every row is visited once per window with no action from the requester.

Top module: `dram_page_ctrl`

## Requirements
- R1: The row is the upper ROW_W bits of `req_addr` and the column is the lower COL_W bits. `mem_addr` carries the row, zero-extended, whenever `mem_ras_n` falls for an access. It carries the column whenever `mem_cas_n` falls, and it stays constant while `mem_cas_n` is low.
- R2: `mem_cas_n` is low only while `mem_ras_n` is low. `mem_we_n` is low only during the column phase of a write, and `mem_din` then carries the write data.
- R3: `mem_ras_n` stays low for at least T_RAS cycles before `mem_cas_n` falls. `mem_cas_n` stays low for exactly T_CAS cycles.
- R4: `mem_ras_n` stays high for at least T_PRE cycles before each fall.
- R5: `rd_valid` rises a fixed number of clock edges after the edge that accepts a read:
  - T_CAS edges when the read hits the open row;
  - T_RAS+T_CAS edges when no row is open;
  - T_PRE+T_RAS+T_CAS edges when a different row is open.
- R6: Every REF_INTERVAL cycles a refresh is scheduled. A refresh is a cycle in which `mem_ras_n` goes low and back high with `mem_cas_n` staying high. The refresh rows start at 0 after reset and increase by one, wrapping modulo 2^ROW_W. Every row is activated within about 2^ROW_W*REF_INTERVAL cycles of its previous activation.
- R7: A pending refresh wins over a waiting request. It closes the open row, so the next access after it pays the full row-open latency.
- R8: `rd_valid` is a single-cycle pulse. `rd_data` then holds the value last written to that address, or 0 if the address has never been written.
- R9: `req_ready` is high only when no row, column, rewrite or refresh phase is running and no refresh is pending. `mem_cas_n` is never low while `req_ready` is high.
- R10: While `rst` is high, and right after it, the following hold: `mem_ras_n`, `mem_cas_n` and `mem_we_n` are high, `rd_valid` is low and `req_ready` is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Controller can accept a request this cycle |
| req_addr | input | ADDR_W | Request address, row in the upper bits |
| req_we | input | 1 | 1 = write, 0 = read |
| req_wdata | input | 1 | Write data bit |
| rd_valid | output | 1 | One-cycle pulse marking returned read data |
| rd_data | output | 1 | Read data bit |
| mem_addr | output | MA_W | Multiplexed row/column address to the memory |
| mem_ras_n | output | 1 | Row strobe, active low |
| mem_cas_n | output | 1 | Column strobe, active low |
| mem_we_n | output | 1 | Write strobe, active low |
| mem_din | output | 1 | Data into the memory |
| mem_dout | input | 1 | Data from the memory during a read column phase |

## Verification
The bench builds the block with 4-bit row and column fields and a 40-cycle refresh interval, and keeps the default phase lengths. The 16 rows are few enough that random traffic produces many open-row hits, row misses and refresh collisions. With these values the whole refresh counter wraps several times within a few thousand cycles, so the row-order check and the retention-gap check reach every row many times over. A behavioural memory in the bench latches the row and column from the strobes, so the returned data tests the address split and the write strobe end to end.

// File: rtl/dram_ctrl_pkg.sv
package dram_ctrl_pkg;

  typedef enum logic [2:0] {
    PH_IDLE, // no row open, waiting
    PH_OPEN, // row open, waiting
    PH_PRE,  // row strobe high, rewrite time
    PH_ACT,  // row strobe low, row access time
    PH_COL,  // column strobe low
    PH_CGAP, // column strobe high, rest of the page cycle
    PH_RACT, // refresh row strobe low
    PH_RPRE  // refresh rewrite time
  } phase_e;

  function automatic logic row_strobe_on(phase_e p);
    return p inside {PH_OPEN, PH_ACT, PH_COL, PH_CGAP, PH_RACT};
  endfunction

endpackage

// File: rtl/dram_refresh_sched.sv
module dram_refresh_sched #(
  parameter int ROW_W        = 8,
  parameter int REF_INTERVAL = 390
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             grant,
  output logic             pending,
  output logic [ROW_W-1:0] ref_row
);
  localparam int TW = (REF_INTERVAL > 2) ? $clog2(REF_INTERVAL) : 1;

  logic [TW-1:0] tick_q;
  logic          wrap;

  assign wrap = (tick_q == TW'(REF_INTERVAL - 1));

  always_ff @(posedge clk) begin
    if (rst) begin
      tick_q  <= '0;
      pending <= 1'b0;
      ref_row <= '0;
    end else begin
      tick_q <= wrap ? '0 : tick_q + 1'b1;
      if (wrap)
        pending <= 1'b1;
      else if (grant)
        pending <= 1'b0;
      if (grant)
        ref_row <= ref_row + 1'b1;
    end
  end
endmodule

// File: rtl/dram_open_row.sv
module dram_open_row #(
  parameter int ROW_W = 8
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             load,
  input  logic             close,
  input  logic [ROW_W-1:0] load_row,
  input  logic [ROW_W-1:0] cmp_row,
  output logic             hit
);
  logic             valid_q;
  logic [ROW_W-1:0] row_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      valid_q <= 1'b0;
      row_q   <= '0;
    end else if (load) begin
      valid_q <= 1'b1;
      row_q   <= load_row;
    end else if (close) begin
      valid_q <= 1'b0;
    end
  end

  assign hit = valid_q && (row_q == cmp_row);
endmodule

// File: rtl/dram_phase_seq.sv
module dram_phase_seq
  import dram_ctrl_pkg::*;
#(
  parameter int T_RAS  = 5,
  parameter int T_CAS  = 1,
  parameter int T_PRE  = 3,
  parameter int T_PAGE = 3
) (
  input  logic   clk,
  input  logic   rst,
  input  logic   req_fire,
  input  logic   row_hit,
  input  logic   ref_pending,
  output phase_e phase_q,
  output phase_e phase_d,
  output logic   last,
  output logic   ref_grant,
  output logic   row_load,
  output logic   row_close
);
  localparam int GAP  = (T_PAGE > T_CAS) ? (T_PAGE - T_CAS) : 1;
  localparam int D1   = (T_RAS > T_PRE) ? T_RAS : T_PRE;
  localparam int D2   = (T_CAS > GAP) ? T_CAS : GAP;
  localparam int DMAX = (D1 > D2) ? D1 : D2;
  localparam int CW   = $clog2(DMAX + 1);

  logic [CW-1:0] cnt_q;
  logic          pre_ref_q, pre_ref_d;

  function automatic logic [CW-1:0] span(phase_e p);
    case (p)
      PH_PRE, PH_RPRE: return CW'(T_PRE - 1);
      PH_ACT, PH_RACT: return CW'(T_RAS - 1);
      PH_COL:          return CW'(T_CAS - 1);
      PH_CGAP:         return CW'(GAP - 1);
      default:         return '0;
    endcase
  endfunction

  assign last = (cnt_q == '0);

  always_comb begin
    phase_d   = phase_q;
    pre_ref_d = pre_ref_q;
    ref_grant = 1'b0;
    row_load  = 1'b0;
    row_close = 1'b0;
    case (phase_q)
      PH_IDLE: begin
        if (ref_pending) begin
          phase_d   = PH_RACT;
          ref_grant = 1'b1;
        end else if (req_fire) begin
          phase_d  = PH_ACT;
          row_load = 1'b1;
        end
      end
      PH_OPEN: begin
        if (ref_pending) begin
          phase_d   = PH_PRE;
          pre_ref_d = 1'b1;
          row_close = 1'b1;
        end else if (req_fire) begin
          if (row_hit) begin
            phase_d = PH_COL;
          end else begin
            phase_d   = PH_PRE;
            pre_ref_d = 1'b0;
            row_close = 1'b1;
          end
        end
      end
      PH_PRE: if (last) begin
        if (pre_ref_q) begin
          phase_d   = PH_RACT;
          ref_grant = 1'b1;
        end else begin
          phase_d  = PH_ACT;
          row_load = 1'b1;
        end
      end
      PH_ACT:  if (last) phase_d = PH_COL;
      PH_COL:  if (last) phase_d = PH_CGAP;
      PH_CGAP: if (last) phase_d = PH_OPEN;
      PH_RACT: if (last) phase_d = PH_RPRE;
      PH_RPRE: if (last) phase_d = PH_IDLE;
      default: phase_d = PH_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      phase_q   <= PH_IDLE;
      cnt_q     <= '0;
      pre_ref_q <= 1'b0;
    end else begin
      phase_q   <= phase_d;
      pre_ref_q <= pre_ref_d;
      if (phase_d != phase_q)
        cnt_q <= span(phase_d);
      else if (!last)
        cnt_q <= cnt_q - 1'b1;
    end
  end
endmodule

// File: rtl/dram_page_ctrl.sv
module dram_page_ctrl
  import dram_ctrl_pkg::*;
#(
  parameter int ROW_W        = 8,
  parameter int COL_W        = 8,
  parameter int ADDR_W       = ROW_W + COL_W,
  parameter int MA_W         = (ROW_W > COL_W) ? ROW_W : COL_W,
  parameter int T_RAS        = 5,
  parameter int T_CAS        = 1,
  parameter int T_PRE        = 3,
  parameter int T_PAGE       = 3,
  parameter int REF_INTERVAL = 390
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              req_valid,
  output logic              req_ready,
  input  logic [ADDR_W-1:0] req_addr,
  input  logic              req_we,
  input  logic              req_wdata,
  output logic              rd_valid,
  output logic              rd_data,
  output logic [MA_W-1:0]   mem_addr,
  output logic              mem_ras_n,
  output logic              mem_cas_n,
  output logic              mem_we_n,
  output logic              mem_din,
  input  logic              mem_dout
);
  logic [ROW_W-1:0] in_row, lat_row, nxt_row, ref_row;
  logic [COL_W-1:0] in_col, lat_col, nxt_col;
  logic             lat_we, lat_wd, nxt_we, nxt_wd;
  logic             req_fire, ref_pending, ref_grant;
  logic             row_hit, row_load, row_close, last;
  phase_e           phase_q, phase_d;

  assign in_row   = req_addr[ADDR_W-1:COL_W];
  assign in_col   = req_addr[COL_W-1:0];
  assign req_ready = ((phase_q == PH_IDLE) || (phase_q == PH_OPEN)) && !ref_pending;
  assign req_fire = req_valid && req_ready;

  assign nxt_row = req_fire ? in_row    : lat_row;
  assign nxt_col = req_fire ? in_col    : lat_col;
  assign nxt_we  = req_fire ? req_we    : lat_we;
  assign nxt_wd  = req_fire ? req_wdata : lat_wd;

  dram_refresh_sched #(
    .ROW_W(ROW_W), .REF_INTERVAL(REF_INTERVAL)
  ) u_refresh (
    .clk(clk), .rst(rst), .grant(ref_grant),
    .pending(ref_pending), .ref_row(ref_row)
  );

  dram_open_row #(.ROW_W(ROW_W)) u_open_row (
    .clk(clk), .rst(rst), .load(row_load), .close(row_close),
    .load_row(nxt_row), .cmp_row(in_row), .hit(row_hit)
  );

  dram_phase_seq #(
    .T_RAS(T_RAS), .T_CAS(T_CAS), .T_PRE(T_PRE), .T_PAGE(T_PAGE)
  ) u_seq (
    .clk(clk), .rst(rst), .req_fire(req_fire), .row_hit(row_hit),
    .ref_pending(ref_pending), .phase_q(phase_q), .phase_d(phase_d),
    .last(last), .ref_grant(ref_grant), .row_load(row_load),
    .row_close(row_close)
  );

  // request capture
  always_ff @(posedge clk) begin
    if (rst) begin
      lat_row <= '0;
      lat_col <= '0;
      lat_we  <= 1'b0;
      lat_wd  <= 1'b0;
    end else if (req_fire) begin
      lat_row <= in_row;
      lat_col <= in_col;
      lat_we  <= req_we;
      lat_wd  <= req_wdata;
    end
  end

  // strobes registered from the next phase so they line up with it
  always_ff @(posedge clk) begin
    if (rst) begin
      mem_ras_n <= 1'b1;
      mem_cas_n <= 1'b1;
      mem_we_n  <= 1'b1;
      mem_din   <= 1'b0;
      mem_addr  <= '0;
    end else begin
      mem_ras_n <= !row_strobe_on(phase_d);
      mem_cas_n <= !(phase_d == PH_COL);
      mem_we_n  <= !((phase_d == PH_COL) && nxt_we);
      if (phase_d == PH_COL)
        mem_din <= nxt_wd;
      if (phase_d == PH_ACT)
        mem_addr <= MA_W'(nxt_row);
      else if (phase_d == PH_COL)
        mem_addr <= MA_W'(nxt_col);
      else if ((phase_d == PH_RACT) && (phase_q != PH_RACT))
        mem_addr <= MA_W'(ref_row);
    end
  end

  // read return
  always_ff @(posedge clk) begin
    if (rst) begin
      rd_valid <= 1'b0;
      rd_data  <= 1'b0;
    end else begin
      rd_valid <= (phase_q == PH_COL) && last && !lat_we;
      if ((phase_q == PH_COL) && last && !lat_we)
        rd_data <= mem_dout;
    end
  end
endmodule

// File: rtl/dram_page_ctrl_chk.sv
module dram_page_ctrl_chk #(
  parameter int MA_W  = 8,
  parameter int T_RAS = 5,
  parameter int T_CAS = 1,
  parameter int T_PRE = 3
) (
  input logic            clk,
  input logic            rst,
  input logic            req_ready,
  input logic            rd_valid,
  input logic [MA_W-1:0] mem_addr,
  input logic            mem_ras_n,
  input logic            mem_cas_n,
  input logic            mem_we_n
);
  logic [7:0] ras_lo_cnt, ras_hi_cnt, cas_lo_cnt;

  always_ff @(posedge clk) begin
    if (rst) begin
      ras_lo_cnt <= '0;
      ras_hi_cnt <= 8'(T_PRE);
      cas_lo_cnt <= '0;
    end else begin
      ras_lo_cnt <= !mem_ras_n ? ((ras_lo_cnt == 8'hFF) ? ras_lo_cnt : ras_lo_cnt + 1'b1) : '0;
      ras_hi_cnt <=  mem_ras_n ? ((ras_hi_cnt == 8'hFF) ? ras_hi_cnt : ras_hi_cnt + 1'b1) : '0;
      cas_lo_cnt <= !mem_cas_n ? ((cas_lo_cnt == 8'hFF) ? cas_lo_cnt : cas_lo_cnt + 1'b1) : '0;
    end
  end

  AST_COL_ADDR_HELD: assert property (@(posedge clk) disable iff (rst)
    (!mem_cas_n && !$past(mem_cas_n)) |-> $stable(mem_addr)); // R1
  AST_CAS_UNDER_RAS: assert property (@(posedge clk) disable iff (rst)
    !mem_cas_n |-> !mem_ras_n); // R2
  AST_WE_IN_CAS: assert property (@(posedge clk) disable iff (rst)
    !mem_we_n |-> !mem_cas_n); // R2
  AST_ROW_TO_COL: assert property (@(posedge clk) disable iff (rst)
    $fell(mem_cas_n) |-> (ras_lo_cnt >= 8'(T_RAS))); // R3
  AST_COL_WIDTH: assert property (@(posedge clk) disable iff (rst)
    $rose(mem_cas_n) |-> (cas_lo_cnt == 8'(T_CAS))); // R3
  AST_REWRITE_TIME: assert property (@(posedge clk) disable iff (rst)
    $fell(mem_ras_n) |-> (ras_hi_cnt >= 8'(T_PRE))); // R4
  AST_RDV_PULSE: assert property (@(posedge clk) disable iff (rst)
    rd_valid |=> !rd_valid); // R8
  AST_READY_QUIET: assert property (@(posedge clk) disable iff (rst)
    req_ready |-> mem_cas_n); // R9
endmodule

bind dram_page_ctrl dram_page_ctrl_chk #(
  .MA_W(MA_W), .T_RAS(T_RAS), .T_CAS(T_CAS), .T_PRE(T_PRE)
) u_chk (
  .clk(clk), .rst(rst), .req_ready(req_ready), .rd_valid(rd_valid),
  .mem_addr(mem_addr), .mem_ras_n(mem_ras_n), .mem_cas_n(mem_cas_n),
  .mem_we_n(mem_we_n)
);

// File: tb/dram_page_ctrl_bench.sv
module dram_page_ctrl_bench;
  localparam int ROW_W = 4, COL_W = 4, ADDR_W = 8, MA_W = 4;
  localparam int ROWS = 16, REF_INT = 40;
  localparam int T_RAS = 5, T_CAS = 1, T_PRE = 3, T_PAGE = 3;
  localparam int GAP_LIMIT = ROWS * REF_INT + 40;

  logic clk = 1'b0, rst = 1'b1;
  logic req_valid = 1'b0, req_we = 1'b0, req_wdata = 1'b0;
  logic [ADDR_W-1:0] req_addr = '0;
  logic req_ready, rd_valid, rd_data, mem_ras_n, mem_cas_n, mem_we_n, mem_din, mem_dout;
  logic [MA_W-1:0] mem_addr;

  always #10 clk = ~clk;

  dram_page_ctrl #(
    .ROW_W(ROW_W), .COL_W(COL_W), .T_RAS(T_RAS), .T_CAS(T_CAS),
    .T_PRE(T_PRE), .T_PAGE(T_PAGE), .REF_INTERVAL(REF_INT)
  ) u_dram_page_ctrl (
    .clk(clk), .rst(rst), .req_valid(req_valid), .req_ready(req_ready),
    .req_addr(req_addr), .req_we(req_we), .req_wdata(req_wdata),
    .rd_valid(rd_valid), .rd_data(rd_data), .mem_addr(mem_addr),
    .mem_ras_n(mem_ras_n), .mem_cas_n(mem_cas_n), .mem_we_n(mem_we_n),
    .mem_din(mem_din), .mem_dout(mem_dout)
  );

  int n_chk = 0, n_err = 0, cyc = 0, ref_count = 0;
  logic cells [256];
  logic shadow [256];
  int last_touch [ROWS];
  logic [ROW_W-1:0] m_row = '0, exp_ref = '0;
  logic prev_ras = 1'b1, saw_cas = 1'b0;
  logic open_valid = 1'b0;
  logic [ROW_W-1:0] open_row = '0;

  // behavioural memory: row latched on row strobe, column on address pins
  assign mem_dout = (!mem_cas_n && mem_we_n) ? cells[{m_row, mem_addr}] : 1'b0;

  task automatic chk(input bit ok, input string what, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_err++;
      $display("FAIL %s actual=%0d expected=%0d", what, act, exp);
    end
  endtask

  always @(posedge clk) cyc <= cyc + 1;

  always @(negedge clk) begin
    if (!rst) begin
      if (!mem_ras_n && prev_ras) begin
        m_row = mem_addr;
        saw_cas = 1'b0;
        chk((cyc - last_touch[mem_addr]) <= GAP_LIMIT, "R6 row activation gap",
            cyc - last_touch[mem_addr], GAP_LIMIT);
        last_touch[mem_addr] = cyc;
      end
      if (!mem_cas_n) begin
        saw_cas = 1'b1;
        if (!mem_we_n) cells[{m_row, mem_addr}] = mem_din;
      end
      if (mem_ras_n && !prev_ras && !saw_cas) begin
        chk(m_row == exp_ref, "R6 refresh row order", m_row, exp_ref);
        exp_ref = exp_ref + 1'b1;
        ref_count++;
        open_valid = 1'b0;  // R7: refresh leaves no row open
      end
      prev_ras = mem_ras_n;
    end
  end

  function automatic int exp_latency(input logic [ROW_W-1:0] r);
    if (!open_valid) return T_RAS + T_CAS;
    if (open_row == r) return T_CAS;
    return T_PRE + T_RAS + T_CAS;
  endfunction

  task automatic do_req(input logic [ADDR_W-1:0] a, input bit we, input bit d);
    int lat;
    bit got;
    req_valid = 1'b1; req_addr = a; req_we = we; req_wdata = d;
    while (!req_ready) @(negedge clk);
    lat = exp_latency(a[ADDR_W-1:COL_W]);
    @(posedge clk);
    @(negedge clk);
    req_valid = 1'b0;
    open_valid = 1'b1;
    open_row = a[ADDR_W-1:COL_W];
    chk(req_ready == 1'b0, "R9 ready low after accept", req_ready, 0);
    if (we) begin
      shadow[a] = d;
    end else begin
      got = 1'b0;
      for (int k = 0; k < 30; k++) begin
        if (rd_valid) begin
          chk(k == lat, "R5 read latency", k, lat);
          chk(rd_data == shadow[a], "R8/R1 read data", rd_data, shadow[a]);
          got = 1'b1;
          break;
        end
        @(negedge clk);
      end
      if (!got) chk(1'b0, "R8 rd_valid missing", 0, 1);
    end
  endtask

  bit done = 1'b0;
  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      n_chk++; n_err++;
      $display("FAIL watchdog expired actual=%0d expected=%0d", cyc, 0);
      $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
      $finish;
    end
  end

  initial begin
    int base;
    for (int i = 0; i < 256; i++) begin cells[i] = 1'b0; shadow[i] = 1'b0; end
    for (int r = 0; r < ROWS; r++) last_touch[r] = 0;
    void'($urandom(32'd4242));
    repeat (4) @(posedge clk);
    @(negedge clk);
    chk(mem_ras_n && mem_cas_n && mem_we_n, "R10 strobes high in reset", {mem_ras_n, mem_cas_n, mem_we_n}, 7);
    chk(!rd_valid, "R10 rd_valid low in reset", rd_valid, 0);
    rst = 1'b0;
    @(negedge clk);
    chk(req_ready, "R10 ready after reset", req_ready, 1);

    // directed: closed-row write, page hit read, miss, boundaries
    do_req(8'h35, 1'b1, 1'b1);
    do_req(8'h35, 1'b0, 1'b0);            // R5 hit
    do_req(8'h72, 1'b0, 1'b0);            // R5 miss with open row
    do_req(8'h7F, 1'b1, 1'b1);
    do_req(8'h7F, 1'b0, 1'b0);
    do_req(8'h00, 1'b1, 1'b1);            // R1 lowest address
    do_req(8'hFF, 1'b1, 1'b1);            // R1 highest address
    do_req(8'h00, 1'b0, 1'b0);
    do_req(8'hFF, 1'b0, 1'b0);
    do_req(8'hF0, 1'b0, 1'b0);            // R1 same row, other column
    // R7: wait for a refresh, then the row must be reopened
    base = ref_count;
    for (int k = 0; k < 200 && ref_count == base; k++) @(negedge clk);
    chk(ref_count > base, "R6 refresh occurs when idle", ref_count, base + 1);
    chk(!open_valid, "R7 refresh closed row", open_valid, 0);
    do_req(8'hF3, 1'b0, 1'b0);

    // random traffic biased towards a few rows
    for (int n = 0; n < 600; n++) begin
      logic [ROW_W-1:0] r;
      logic [COL_W-1:0] c;
      case ($urandom % 4)
        0: r = 4'd2;
        1: r = 4'd9;
        default: r = ROW_W'($urandom);
      endcase
      c = COL_W'($urandom);
      do_req({r, c}, ($urandom % 2) == 1, ($urandom % 2) == 1);
      repeat ($urandom % 3) @(negedge clk);
    end

    // idle period: refresh alone must keep every row inside the window
    repeat (2 * ROWS * REF_INT) @(negedge clk);
    chk(ref_count >= (cyc / REF_INT) - 2, "R6 refresh cadence", ref_count, (cyc / REF_INT) - 2);
    for (int r = 0; r < ROWS; r++)
      chk((cyc - last_touch[r]) <= GAP_LIMIT, "R6 final row gap", cyc - last_touch[r], GAP_LIMIT);

    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
    $finish;
  end
endmodule